// File: doc/BRIEF.md
# Complementary Drive Short Guard

This block watches the three complementary pairs of a motor-drive stage. It raises an alarm when both lines of any pair sit low at the same time, which would short the bridge. The six drive levels come from a separate timing domain, so the block first brings them into its own clock with a synchronizer. It then compares each pair on every clock edge. A detection sets a sticky flag. While that flag is set, the flag alone forces every high-current pin into high impedance. If software has enabled it, the flag also holds an interrupt request.

Software reaches the block through one 16-bit control/status register on a simple select/read/write bus. The register holds three bits: the flag, a comparison enable and an interrupt enable. Software clears the flag in two steps. It first reads the register and sees the flag as 1, and then it writes 0 to the flag bit. Only the power-on reset clears the register. A manual reset only flushes the synchronizer and leaves the register and its flag untouched.

Top module: `drive_short_guard`

## Requirements
- R1: Register layout: bit 15 is the flag, bit 9 is the compare enable and bit 8 is the interrupt enable. A read (`csr_sel` and `csr_rd` high) returns this value on `csr_rdata`. All other bits always read as 0, even after ones are written to them.
- R2: With compare enable at 1, both lines of any pair low sets the flag. Pair k is `drv_lvl[2k+1:2k]`. The drive levels pass through a 2-stage synchronizer, so the flag and the pins respond after the third rising edge following a change at the input.
- R3: With compare enable at 0, low-low levels on any pair have no effect on the flag.
- R4: Writing 1 to bit 15 never sets the flag.
- R5: Writing 0 to bit 15 clears the flag only if an earlier read returned the flag as 1. Any write uses up that qualification. A 0 written without it leaves the flag at 1.
- R6: `pin_hiz` is all ones while the flag is 1 and all zeros while it is 0.
- R7: `irq` is 1 exactly while both the flag and the interrupt enable are 1.
- R8: Power-on reset (`por_n` low) sets the whole register to 0x0000.
- R9: A manual reset (`mrst_n` low) leaves all register contents unchanged.
- R10: If a detection and a valid clearing write fall in the same cycle, the flag stays 1.
- R11: No detection occurs when only one line of each pair is low, or when every line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, synchronous, active low; flushes the synchronizer only |
| csr_sel | input | 1 | Register select |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 16 | Write data |
| csr_rdata | output | 16 | Read data; zero when no read is selected |
| drv_lvl | input | 6 | Drive levels, pair k on bits 2k+1:2k |
| pin_hiz | output | 6 | Per-pin high-impedance enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle:
- the reserved bits read as zero;
- the flag never falls without a qualified write in the cycle before;
- the flag never rises while comparison is disabled or no pair is shorted;
- a detection always wins against a clear.

The bench's scenarios cover the rest:
- the exact synchronizer latency;
- the read-then-write order of clearing;
- the flag surviving a manual reset;
- the per-pattern detection results.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
   localparam int unsigned CSR_W      = 16;
   localparam int unsigned FLAG_POS   = 15;
   localparam int unsigned CMP_EN_POS = 9;
   localparam int unsigned IRQ_EN_POS = 8;

   typedef struct packed {
      logic flag;
      logic cmp_en;
      logic irq_en;
   } dsg_csr_t;

   function automatic logic [CSR_W-1:0] dsg_pack(input dsg_csr_t c);
      logic [CSR_W-1:0] v;
      v             = '0;
      v[FLAG_POS]   = c.flag;
      v[CMP_EN_POS] = c.cmp_en;
      v[IRQ_EN_POS] = c.irq_en;
      return v;
   endfunction
endpackage

// File: rtl/dsg_sync.sv
module dsg_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("dsg_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            stage_q <= '1;
         end else if (!mrst_n) begin
            stage_q <= '1;
         end else begin
            stage_q[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end
      assign q = stage_q[STAGES-1];
   end
endmodule

// File: rtl/dsg_pair_cmp.sv
module dsg_pair_cmp #(
   parameter int unsigned NUM_PAIRS = 3
) (
   input  logic [2*NUM_PAIRS-1:0] lvl,
   input  logic                   cmp_en,
   output logic [NUM_PAIRS-1:0]   short_vec,
   output logic                   short_any
);
   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      assign short_vec[k] = cmp_en & ~lvl[2*k] & ~lvl[2*k+1];
   end
   assign short_any = |short_vec;
endmodule

// File: rtl/dsg_csr.sv
module dsg_csr
   import dsg_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             sel,
   input  logic             rd,
   input  logic             wr,
   input  logic [CSR_W-1:0] wdata,
   input  logic             set_req,
   output dsg_csr_t         csr,
   output logic             armed,
   output logic [CSR_W-1:0] rdata
);
   dsg_csr_t csr_q;
   logic     armed_q;
   logic     wr_hit, rd_hit, clr_ok;
   logic     unused_wbits;

   assign wr_hit = sel & wr;
   assign rd_hit = sel & rd;
   assign clr_ok = wr_hit & ~wdata[FLAG_POS] & armed_q;
   assign unused_wbits = ^{wdata[14:10], wdata[7:0]};

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         csr_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (wr_hit) begin
            csr_q.cmp_en <= wdata[CMP_EN_POS];
            csr_q.irq_en <= wdata[IRQ_EN_POS];
            armed_q      <= 1'b0;
         end else if (rd_hit && csr_q.flag) begin
            armed_q <= 1'b1;
         end
         if (set_req) begin
            csr_q.flag <= 1'b1;
         end else if (clr_ok) begin
            csr_q.flag <= 1'b0;
         end
      end
   end

   assign csr   = csr_q;
   assign armed = armed_q;
   assign rdata = rd_hit ? dsg_pack(csr_q) : '0;
endmodule

// File: rtl/drive_short_guard.sv
module drive_short_guard
   import dsg_pkg::*;
#(
   parameter int unsigned NUM_PAIRS   = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [2*NUM_PAIRS-1:0] HC_MASK = '1
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   mrst_n,
   input  logic                   csr_sel,
   input  logic                   csr_rd,
   input  logic                   csr_wr,
   input  logic [15:0]            csr_wdata,
   output logic [15:0]            csr_rdata,
   input  logic [2*NUM_PAIRS-1:0] drv_lvl,
   output logic [2*NUM_PAIRS-1:0] pin_hiz,
   output logic                   irq
);
   localparam int unsigned NPINS = 2 * NUM_PAIRS;

   if (NUM_PAIRS < 1) begin : g_bad_pairs
      $error("drive_short_guard: NUM_PAIRS must be at least 1");
   end
   if (CSR_W != 16) begin : g_bad_csr
      $error("drive_short_guard: register width must be 16");
   end

   logic [NPINS-1:0]     lvl_s;
   logic [NUM_PAIRS-1:0] short_vec;
   logic                 short_any;
   dsg_csr_t             csr;
   logic                 armed;
   logic                 unused_vec;

   dsg_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .d(drv_lvl), .q(lvl_s)
   );

   dsg_pair_cmp #(.NUM_PAIRS(NUM_PAIRS)) u_cmp (
      .lvl(lvl_s), .cmp_en(csr.cmp_en), .short_vec(short_vec), .short_any(short_any)
   );

   dsg_csr u_csr (
      .clk(clk), .por_n(por_n), .sel(csr_sel), .rd(csr_rd), .wr(csr_wr),
      .wdata(csr_wdata), .set_req(short_any), .csr(csr), .armed(armed),
      .rdata(csr_rdata)
   );

   assign unused_vec = ^short_vec;

   for (genvar j = 0; j < NPINS; j++) begin : g_pin
      if (HC_MASK[j]) begin : g_hc
         assign pin_hiz[j] = csr.flag;
      end else begin : g_lc
         assign pin_hiz[j] = 1'b0;
      end
   end

   assign irq = csr.flag & csr.irq_en;
endmodule

// File: rtl/drive_short_guard_chk.sv
module drive_short_guard_chk #(
   parameter int unsigned NPINS = 6,
   parameter logic [NPINS-1:0] HC_MASK = '1
) (
   input logic             clk,
   input logic             por_n,
   input logic             csr_sel,
   input logic             csr_wr,
   input logic [15:0]      csr_rdata,
   input logic [NPINS-1:0] pin_hiz,
   input logic             irq,
   input logic             flag,
   input logic             cmp_en,
   input logic             armed,
   input logic             short_any
);
   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (csr_rdata & 16'h7CFF) == 16'h0000);

   // R5
   clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(flag) |-> $past(csr_sel && csr_wr && armed));

   // R3
   no_set_disabled_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!cmp_en && !flag) |=> !flag);

   // R4
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!short_any && !flag) |=> !flag);

   // R10
   set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
      short_any |=> flag);

   // R7
   irq_implies_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
      irq |-> (pin_hiz == HC_MASK));
endmodule

bind drive_short_guard drive_short_guard_chk #(.NPINS(2*NUM_PAIRS), .HC_MASK(HC_MASK)) u_chk (
   .clk(clk), .por_n(por_n), .csr_sel(csr_sel), .csr_wr(csr_wr),
   .csr_rdata(csr_rdata), .pin_hiz(pin_hiz), .irq(irq), .flag(csr.flag),
   .cmp_en(csr.cmp_en), .armed(armed), .short_any(short_any)
);

// File: tb/tb_drive_short_guard.sv
`timescale 1ns/1ps
module tb_drive_short_guard;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        mrst_n = 1'b1;
   logic        csr_sel = 1'b0, csr_rd = 1'b0, csr_wr = 1'b0;
   logic [15:0] csr_wdata = '0;
   logic [15:0] csr_rdata;
   logic [5:0]  drv_lvl = 6'h3F;
   logic [5:0]  pin_hiz;
   logic        irq;
   int          errors = 0;
   int          checks = 0;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   drive_short_guard dut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .csr_sel(csr_sel),
      .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .drv_lvl(drv_lvl), .pin_hiz(pin_hiz), .irq(irq)
   );

   // {cmp_en, expected flag, drv_lvl[5:0]}
   localparam logic [7:0] VEC [0:7] = '{
      8'b1_0_111111,  // R11 all high
      8'b1_1_111100,  // R2 pair 0 low-low
      8'b1_1_110011,  // R2 pair 1 low-low
      8'b1_1_001111,  // R2 pair 2 low-low
      8'b1_0_101010,  // R11 one line of each pair low
      8'b1_0_010101,  // R11 the other line of each pair low
      8'b1_1_000000,  // R2 every pair low
      8'b0_0_000000   // R3 compare disabled
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_por();
      @(negedge clk);
      por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
   endtask

   task automatic csr_write(input logic [15:0] d);
      @(negedge clk);
      csr_sel = 1'b1; csr_wr = 1'b1; csr_wdata = d;
      @(negedge clk);
      csr_sel = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
   endtask

   task automatic csr_read(output logic [15:0] d);
      @(negedge clk);
      csr_sel = 1'b1; csr_rd = 1'b1;
      #1 d = csr_rdata;
      @(negedge clk);
      csr_sel = 1'b0; csr_rd = 1'b0;
   endtask

   task automatic drive(input logic [5:0] v);
      @(negedge clk);
      drv_lvl = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] rv;
      repeat (2) @(negedge clk);
      por_n = 1'b1;

      // R8 reset state
      csr_read(rv);
      check("R8 reset value", rv, 16'h0000);
      check("R8 reset hiz", {10'h0, pin_hiz}, 16'h0000);
      check("R8 reset irq", {15'h0, irq}, 16'h0000);

      // R1 / R4 reserved bits and flag not settable by write
      csr_write(16'hFFFF);
      csr_read(rv);
      check("R1 R4 write ones", rv, 16'h0300);

      // R2 latency: two edges after change, no response yet
      @(negedge clk);
      drv_lvl = 6'h3C;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2 not before third edge", {10'h0, pin_hiz}, 16'h0000);
      @(posedge clk);
      @(negedge clk);
      check("R2 after third edge", {10'h0, pin_hiz}, 16'h003F);
      check("R7 irq with enable", {15'h0, irq}, 16'h0001);
      drive(6'h3F);

      // R5 write 0 without prior read leaves flag
      csr_write(16'h0200);
      check("R5 unqualified clear", {10'h0, pin_hiz}, 16'h003F);
      check("R7 irq disabled", {15'h0, irq}, 16'h0000);
      // R9 manual reset keeps register
      @(negedge clk);
      mrst_n = 1'b0;
      repeat (2) @(negedge clk);
      mrst_n = 1'b1;
      csr_read(rv);
      check("R9 survives manual reset", rv, 16'h8200);
      csr_write(16'h0200);
      csr_read(rv);
      check("R5 R6 qualified clear", rv, 16'h0200);
      check("R6 hiz released", {10'h0, pin_hiz}, 16'h0000);

      // R10 set beats a qualified clear
      drive(6'h33);
      csr_read(rv);
      check("R1 flag readback", rv, 16'h8200);
      csr_write(16'h0200);
      check("R10 set priority", {10'h0, pin_hiz}, 16'h003F);
      drive(6'h3F);
      // R5 qualification consumed by the previous write
      csr_write(16'h0200);
      check("R5 arm consumed", {10'h0, pin_hiz}, 16'h003F);

      // R8 power-on reset clears flag
      do_por();
      csr_read(rv);
      check("R8 por clears", rv, 16'h0000);

      // Vector table: R2 R3 R11
      for (int i = 0; i < 8; i++) begin
         do_por();
         csr_write(VEC[i][7] ? 16'h0200 : 16'h0000);
         drive(VEC[i][5:0]);
         check(VEC[i][7] ? (VEC[i][6] ? "R2 vector hiz" : "R11 vector hiz") : "R3 vector hiz",
               {10'h0, pin_hiz}, VEC[i][6] ? 16'h003F : 16'h0000);
         csr_read(rv);
         check("R2 R3 R11 vector flag", rv & 16'h8000, VEC[i][6] ? 16'h8000 : 16'h0000);
         @(negedge clk);
         drv_lvl = 6'h3F;
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule